// File: doc/BRIEF.md
# Received all-ones alarm detector

This block sits behind the line decoder of a receive path and decides whether the incoming bit stream has collapsed into an unbroken run of ones, the pattern an upstream node sends to report a failure. It counts zero bits in the decoded receive data. A sample counts only when its valid qualifier is high. The counting is done over observation windows whose edges come from an external, periodic reset-alarm strobe. The block has no timer of its own, so the window length is set by whoever generates the strobe.

The strobe may be asynchronous to the receive clock. It passes through a synchroniser, and one edge of the synchronised strobe marks the end of one window and the start of the next. At each boundary the window that just closed is graded as "short" if it held fewer than the zero threshold (three by default), and "met" otherwise. A history of recent grades drives the alarm. The alarm is raised only when the closing window and the window before it were both short. It is dropped as soon as either of those two windows met the threshold. The alarm output changes only at window boundaries.

Top module: `rx_ones_alarm`

## Requirements
- R1: While reset is asserted the alarm output is low. Reset also clears the window history, so a single short window after reset does not raise the alarm.
- R2: A receive sample counts as a zero only when the valid input is high and the data input is 0. Data presented while the valid input is low has no effect on the count.
- R3: The per-window zero count saturates at the threshold. A window holding more zeros than the threshold, for example five, is graded met and never wraps back to short.
- R4: A window boundary is one rising edge of the synchronised strobe. A strobe held high for many cycles produces exactly one boundary, and its falling edge produces none.
- R5: At a boundary the closing window is short if it contained fewer than 3 zeros and met if it contained 3 or more, counting the sample taken in the boundary cycle itself.
- R6: At a boundary the alarm is set high when the closing window and the previous window were both short.
- R7: At a boundary the alarm is cleared when either the closing window or the previous window met the threshold.
- R8: The alarm never changes between boundaries. A strobe rise first sampled at clock edge k updates the alarm at edge k+2; edges k and k+1 still show the old value.
- R9: The zero count restarts at every boundary, so zeros in one window never carry into the next. Two windows of 2 zeros each are both short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Qualifies rx_data_i for this cycle |
| rx_data_i | input | 1 | Decoded receive bit |
| win_strobe_i | input | 1 | External reset-alarm strobe, may be asynchronous to clk |
| alarm_o | output | 1 | High while an all-ones condition is declared |

## Verification
The hardest situation to reach is the alarm sitting high while the current window is already filling with zeros. The output must hold, and then clear exactly two clock edges after the strobe rise reaches the synchroniser. A window-by-window vector table walks the two-entry history through every pair of short and met grades, so set and clear each happen from both history states. Directed cases then check the alarm before and after each boundary, hold the strobe high across many cycles, feed zeros with the valid qualifier low, and assert reset while the alarm is high.

// File: rtl/rx_ones_alarm_pkg.sv
package rx_ones_alarm_pkg;

   // Grade of a window that has just closed
   typedef enum logic {
      WIN_MET   = 1'b0,
      WIN_SHORT = 1'b1
   } win_grade_e;

   function automatic int cnt_width(input int thresh);
      return $clog2(thresh + 1);
   endfunction

endpackage

// File: rtl/rx_ones_alarm_strobe.sv
module rx_ones_alarm_strobe #(
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_RISE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic bound_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   synced;

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_i};
         prev_q <= synced;
      end
   end

   generate
      if (EDGE_RISE) begin : g_rise
         assign bound_o = synced & ~prev_q;
      end else begin : g_fall
         assign bound_o = ~synced & prev_q;
      end
   endgenerate

endmodule

// File: rtl/rx_ones_alarm_count.sv
module rx_ones_alarm_count
   import rx_ones_alarm_pkg::*;
#(
   parameter int ZERO_THRESH = 3,
   localparam int CNT_W      = cnt_width(ZERO_THRESH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic             data_i,
   input  logic             bound_i,
   output logic [CNT_W-1:0] cnt_o,
   output win_grade_e       grade_o
);

   localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(ZERO_THRESH);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_now;
   logic             zero_seen;

   assign zero_seen = valid_i & ~data_i;
   assign cnt_inc   = (cnt_q >= THRESH_V) ? THRESH_V : cnt_q + 1'b1;
   assign cnt_now   = zero_seen ? cnt_inc : cnt_q;
   assign grade_o   = (cnt_now < THRESH_V) ? WIN_SHORT : WIN_MET;
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bound_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_now;
      end
   end

endmodule

// File: rtl/rx_ones_alarm_hist.sv
module rx_ones_alarm_hist
   import rx_ones_alarm_pkg::*;
#(
   parameter int HIST_DEPTH = 2,
   localparam int PREV_W    = HIST_DEPTH - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bound_i,
   input  win_grade_e        grade_i,
   output logic [PREV_W-1:0] prev_short_o,
   output logic              alarm_o
);

   logic [PREV_W-1:0] prev_q;
   logic [PREV_W-1:0] prev_d;
   logic              new_short;

   assign new_short = (grade_i == WIN_SHORT);

   generate
      if (PREV_W == 1) begin : g_one
         assign prev_d = new_short;
      end else begin : g_shift
         assign prev_d = {prev_q[PREV_W-2:0], new_short};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         alarm_o <= 1'b0;
      end else if (bound_i) begin
         prev_q  <= prev_d;
         alarm_o <= new_short & (&prev_q);
      end
   end

   assign prev_short_o = prev_q;

endmodule

// File: rtl/rx_ones_alarm.sv
module rx_ones_alarm
   import rx_ones_alarm_pkg::*;
#(
   parameter int ZERO_THRESH = 3,
   parameter int HIST_DEPTH  = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_RISE   = 1'b1,
   localparam int CNT_W      = cnt_width(ZERO_THRESH),
   localparam int PREV_W     = HIST_DEPTH - 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_valid_i,
   input  logic rx_data_i,
   input  logic win_strobe_i,
   output logic alarm_o
);

   generate
      if (ZERO_THRESH < 1) begin : g_bad_thresh
         $error("rx_ones_alarm: ZERO_THRESH must be at least 1");
      end
      if (HIST_DEPTH < 2) begin : g_bad_depth
         $error("rx_ones_alarm: HIST_DEPTH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rx_ones_alarm: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              bound_w;
   logic [CNT_W-1:0]  cnt_w;
   win_grade_e        grade_w;
   logic [PREV_W-1:0] prev_w;

   rx_ones_alarm_strobe #(
      .SYNC_STAGES (SYNC_STAGES),
      .EDGE_RISE   (EDGE_RISE)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (win_strobe_i),
      .bound_o  (bound_w)
   );

   rx_ones_alarm_count #(
      .ZERO_THRESH (ZERO_THRESH)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (rx_valid_i),
      .data_i  (rx_data_i),
      .bound_i (bound_w),
      .cnt_o   (cnt_w),
      .grade_o (grade_w)
   );

   rx_ones_alarm_hist #(
      .HIST_DEPTH (HIST_DEPTH)
   ) u_hist (
      .clk          (clk),
      .rst_n        (rst_n),
      .bound_i      (bound_w),
      .grade_i      (grade_w),
      .prev_short_o (prev_w),
      .alarm_o      (alarm_o)
   );

endmodule

// File: rtl/rx_ones_alarm_chk.sv
module rx_ones_alarm_chk #(
   parameter int ZERO_THRESH = 3,
   parameter int CNT_W       = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bound,
   input logic             win_short,
   input logic             prev_all_short,
   input logic [CNT_W-1:0] cnt,
   input logic             alarm
);

   // R1: alarm is low whenever reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_low: assert (!alarm);
      end
   end

   // R3: count never passes the threshold
   a_r3_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(ZERO_THRESH));

   // R9: count restarts after each boundary
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      bound |=> (cnt == '0));

   // R6: two short windows raise the alarm
   a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bound && win_short && prev_all_short) |=> alarm);

   // R7: any met window in the pair drops the alarm
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bound && (!win_short || !prev_all_short)) |=> !alarm);

   // R8: alarm only moves on the edge that follows a boundary
   a_r8_only_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !bound |=> $stable(alarm));

endmodule

bind rx_ones_alarm rx_ones_alarm_chk #(
   .ZERO_THRESH (ZERO_THRESH),
   .CNT_W       (CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bound          (bound_w),
   .win_short      (grade_w == rx_ones_alarm_pkg::WIN_SHORT),
   .prev_all_short (&prev_w),
   .cnt            (cnt_w),
   .alarm          (alarm_o)
);

// File: tb/rx_ones_alarm_tb.sv
module rx_ones_alarm_tb;

   logic clk = 1'b0;
   logic rst_n;
   logic rx_valid_i;
   logic rx_data_i;
   logic win_strobe_i;
   logic alarm_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   rx_ones_alarm u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid_i   (rx_valid_i),
      .rx_data_i    (rx_data_i),
      .win_strobe_i (win_strobe_i),
      .alarm_o      (alarm_o)
   );

   // zeros per window and expected alarm after its boundary
   localparam int NVEC = 10;
   localparam int VEC_NZ [NVEC] = '{5, 0, 2, 1, 3, 0, 0, 4, 2, 2};
   localparam bit VEC_AL [NVEC] = '{0, 0, 1, 1, 0, 0, 1, 0, 0, 1};

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: alarm_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Feed nz valid zeros and 6 valid ones, then close the window.
   // zv selects whether the zeros carry a valid qualifier.
   task automatic run_window(input int nz, input bit zv, input bit exp,
                             input string req);
      logic old;
      for (int i = 0; i < nz; i++) begin
         @(negedge clk); rx_valid_i = zv; rx_data_i = 1'b0;
      end
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); rx_valid_i = 1'b1; rx_data_i = 1'b1;
      end
      @(negedge clk); rx_valid_i = 1'b0; rx_data_i = 1'b1;
      old = alarm_o;
      win_strobe_i = 1'b1;                 // sampled at edge k
      @(negedge clk);                      // after k
      @(negedge clk);                      // after k+1
      check("R8", alarm_o, old);           // R8: not yet updated
      @(negedge clk);                      // after k+2
      check(req, alarm_o, exp);
      win_strobe_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R4", alarm_o, exp);           // R4: falling edge is no boundary
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, alarm_o=%b expected end of test", alarm_o);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rx_valid_i = 1'b0; rx_data_i = 1'b1; win_strobe_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", alarm_o, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", alarm_o, 1'b0);

      // Table walk: R5 grades, R6 set, R7 clear, R3 saturation (5 zeros),
      // R9 restart (two windows of 2 zeros)
      for (int v = 0; v < NVEC; v++) begin
         string req;
         if (v > 0 && VEC_AL[v] && !VEC_AL[v-1]) req = "R6";
         else if (v > 0 && !VEC_AL[v] && VEC_AL[v-1]) req = "R7";
         else if (v == 0) req = "R3";
         else if (v == 9) req = "R9";
         else req = "R5";
         run_window(VEC_NZ[v], 1'b1, VEC_AL[v], req);
      end

      // R2: zeros without valid do not count; alarm stays high
      run_window(5, 1'b0, 1'b1, "R2");

      // R8: alarm holds while zeros arrive mid-window
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); rx_valid_i = 1'b1; rx_data_i = 1'b0;
         check("R8", alarm_o, 1'b1);
      end
      run_window(0, 1'b1, 1'b0, "R7");

      // R4: a long strobe is one boundary
      run_window(0, 1'b1, 1'b0, "R5");
      @(negedge clk); win_strobe_i = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); rx_valid_i = 1'b1; rx_data_i = 1'b1;
      end
      check("R6", alarm_o, 1'b1);          // R6: second short window closed
      win_strobe_i = 1'b0; rx_valid_i = 1'b0;
      repeat (3) @(negedge clk);
      run_window(0, 1'b1, 1'b1, "R4");     // R4: no hidden extra boundary

      // R1: reset while alarm high, then history must be cleared
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1", alarm_o, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_window(0, 1'b1, 1'b0, "R1");
      run_window(0, 1'b1, 1'b1, "R6");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule